// File: doc/BRIEF.md
# GPIO Port with Per-Line Interrupt Detection

The block is a 32-line general-purpose I/O port that sits behind a simple 32-bit register bus. Software programs which lines drive the pads and what value they drive. It reads the pad levels back through a two-flop synchroniser. Each input line can raise an interrupt on a level or on an edge. A status register latches the interrupt events. The status bits are combined with a mask register into one interrupt request line.

Each line owns a 2-bit detection mode, and the upper bit chooses edge or level. A separate per-line bit overrides the mode so that the line triggers on both edges. That override register can be removed at build time. Edges are found by comparing the current synchronised sample with the sample one cycle older. Level conditions are evaluated on every cycle.

The bus is a single-cycle strobe interface, and only whole 32-bit words are accessed. Read data is combinational while `bus_sel` is high and `bus_write` is low, and writes take effect at the next rising clock edge.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is low, and on the first cycle after it, every register reads 0, `pad_out`, `pad_oe` and `irq_out` are 0. Reset is synchronous and active low.
- R2: `pad_oe` equals the direction register (offset 0x04, 1 = output) and `pad_out` equals the data register (offset 0x00).
- R3: A read of offset 0x00 returns the data register bit on output lines and the synchronised pad bit on input lines.
- R4: A read of offset 0x08 returns the synchronised pad bits with output lines forced to 0. A pad change is visible there two clock edges after it is applied.
- R5: On an input line in level mode, the status bit is set on every cycle in which the sampled level equals the active level. Mode 00 is active low and mode 01 is active high.
- R6: Line n's mode sits at bits 2n+1:2n of a 64-bit configuration. Offset 0x0C holds lines 0-15 and offset 0x10 holds lines 16-31. Mode 10 sets status on a rising edge and mode 11 sets it on a falling edge.
- R7: When a line's bit in the both-edges register (offset 0x1C) is 1, any change of its sampled level sets its status bit, whatever its mode.
- R8: Lines whose direction bit is 1 never set their status bit.
- R9: Writing 1 to a bit of the status register (offset 0x18) clears it, and writing 0 leaves it unchanged. The clear wins over a set in the same cycle, so an active level sets the bit again on the next cycle.
- R10: `irq_out` is 1 exactly when some bit is set in both the status register and the mask register (offset 0x14).
- R11: With `HAS_BOTH_EDGE` = 0, offset 0x1C reads 0, writes to it are ignored, and no line detects both edges.
- R12: Reads of offsets that are not one of the eight word-aligned registers at 0x00-0x1C return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Levels driven to the pads |
| pad_oe | output | 32 | Per-pad output enable |
| irq_out | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a falling edge on a line that is configured for rising edges, where only the both-edges override can set the status bit. The stimulus first arms the override and raises the pad. It then clears the status so that the rising event is gone, and drops the pad. A second instance built without the override receives the same traffic and must leave the bit clear. The level re-set after a clear is reached the same way: the pad is held active, a one-bit clear is written, and the status is read back on the very next access.

// File: rtl/gpio_irq_pkg.sv
// Shared definitions for the GPIO interrupt port.
// Assumes: registers are 32-bit words spaced 4 bytes apart in the order of reg_sel_e.
package gpio_irq_pkg;

    // Register index; the byte offset of each register is index * 4.
    typedef enum logic [2:0] {
        RS_DATA  = 3'd0,
        RS_DIR   = 3'd1,
        RS_PAD   = 3'd2,
        RS_CFGLO = 3'd3,
        RS_CFGHI = 3'd4,
        RS_MASK  = 3'd5,
        RS_STAT  = 3'd6,
        RS_BOTH  = 3'd7
    } reg_sel_e;

    // Result of address decode.
    typedef struct packed {
        logic     hit;
        reg_sel_e which;
    } reg_dec_t;

    // Bit positions inside a line's 2-bit mode field.
    localparam int unsigned MODE_POL_BIT  = 0;
    localparam int unsigned MODE_EDGE_BIT = 1;
    localparam int unsigned MODE_W        = 2;

endpackage

// File: rtl/gpio_in_sync.sv
// Multi-flop synchroniser for asynchronous pad inputs, plus one history stage.
// Assumes: each bit is synchronised on its own (no multi-bit coherence is needed).
// 'sampled' is the synchronised value and 'prior' is the sample one cycle older.
module gpio_in_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] sampled,
    output logic [W-1:0] prior
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop captures the raw pad value.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= d;
            end
        end else begin : g_next
            // Later flops resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    // History flop used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prior <= '0;
        else        prior <= stg[STAGES-1];
    end

    assign sampled = stg[STAGES-1];

endmodule

// File: rtl/gpio_reg_decode.sv
// Decodes a byte address into one of eight word registers.
// Assumes: ADDR_W >= 6. Misaligned or out-of-window addresses give hit = 0.
module gpio_reg_decode
    import gpio_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_dec_t          dec
);

    localparam int unsigned IDX_LO = 2;
    localparam int unsigned IDX_HI = 4;

    // Word-aligned and inside the 32-byte window.
    always_comb begin
        dec.hit   = (addr[IDX_LO-1:0] == '0) && (addr[ADDR_W-1:IDX_HI+1] == '0);
        dec.which = reg_sel_e'(addr[IDX_HI:IDX_LO]);
    end

endmodule

// File: rtl/gpio_line_detect.sv
// Interrupt condition for a single line, evaluated every cycle.
// Assumes: cur/prev are synchronised samples one cycle apart.
// The both-edges override beats the mode, and output lines never fire.
module gpio_line_detect
    import gpio_irq_pkg::*;
(
    input  logic              cur,
    input  logic              prev,
    input  logic              is_input,
    input  logic [MODE_W-1:0] mode,
    input  logic              both,
    output logic              hit
);

    logic changed;

    // Select the detection rule for this line.
    always_comb begin
        changed = cur ^ prev;
        if (!is_input)                 hit = 1'b0;
        else if (both)                 hit = changed;
        else if (mode[MODE_EDGE_BIT])  hit = changed && (cur != mode[MODE_POL_BIT]);
        else                           hit = (cur == mode[MODE_POL_BIT]);
    end

endmodule

// File: rtl/gpio_irq_port.sv
// GPIO port top: register file, read mux, pad synchroniser, per-line detectors
// and interrupt aggregation.
// Assumes: LINES = 32 (the configuration word pair covers LINES/2 lines each),
// single-cycle full-word accesses, ADDR_W >= 6.
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int unsigned LINES         = 32,
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter bit          HAS_BOTH_EDGE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  pad_in,
    output logic [LINES-1:0]  pad_out,
    output logic [LINES-1:0]  pad_oe,
    output logic              irq_out
);

    localparam int unsigned CFG_W = LINES * MODE_W;

    reg_dec_t           dec;
    logic               wr_hit;
    logic [LINES-1:0]   data_q;
    logic [LINES-1:0]   dir_q;
    logic [CFG_W-1:0]   cfg_q;
    logic [LINES-1:0]   mask_q;
    logic [LINES-1:0]   status_q;
    logic [LINES-1:0]   edge_q;
    logic [LINES-1:0]   samp;
    logic [LINES-1:0]   prior;
    logic [LINES-1:0]   hit;
    logic [LINES-1:0]   clr;
    logic [LINES-1:0]   rd_mux;

    gpio_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    gpio_in_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d       (pad_in),
        .sampled (samp),
        .prior   (prior)
    );

    for (genvar n = 0; n < LINES; n++) begin : g_line
        gpio_line_detect u_det (
            .cur      (samp[n]),
            .prev     (prior[n]),
            .is_input (~dir_q[n]),
            .mode     (cfg_q[MODE_W*n +: MODE_W]),
            .both     (edge_q[n]),
            .hit      (hit[n])
        );
    end

    assign wr_hit = bus_sel && bus_write && dec.hit;

    // Plain configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            cfg_q  <= '0;
            mask_q <= '0;
        end else if (wr_hit) begin
            case (dec.which)
                RS_DATA:  data_q              <= bus_wdata;
                RS_DIR:   dir_q               <= bus_wdata;
                RS_CFGLO: cfg_q[LINES-1:0]    <= bus_wdata;
                RS_CFGHI: cfg_q[CFG_W-1:LINES] <= bus_wdata;
                RS_MASK:  mask_q              <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Both-edges override register, present only when configured.
    if (HAS_BOTH_EDGE) begin : g_both
        always_ff @(posedge clk) begin
            if (!rst_n)                            edge_q <= '0;
            else if (wr_hit && dec.which == RS_BOTH) edge_q <= bus_wdata;
        end
    end else begin : g_no_both
        assign edge_q = '0;
    end

    // Write-one-to-clear mask for the status register.
    always_comb begin
        clr = (wr_hit && dec.which == RS_STAT) ? bus_wdata : '0;
    end

    // Status: latch detector hits; a clear in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q | hit) & ~clr;
    end

    // Read data selection.
    always_comb begin
        case (dec.which)
            RS_DATA:  rd_mux = (data_q & dir_q) | (samp & ~dir_q);
            RS_DIR:   rd_mux = dir_q;
            RS_PAD:   rd_mux = samp & ~dir_q;
            RS_CFGLO: rd_mux = cfg_q[LINES-1:0];
            RS_CFGHI: rd_mux = cfg_q[CFG_W-1:LINES];
            RS_MASK:  rd_mux = mask_q;
            RS_STAT:  rd_mux = status_q;
            RS_BOTH:  rd_mux = edge_q;
            default:  rd_mux = '0;
        endcase
    end

    // Drive read data only for a decoded read.
    assign bus_rdata = (bus_sel && !bus_write && dec.hit) ? rd_mux : '0;

    assign pad_out = data_q;
    assign pad_oe  = dir_q;
    assign irq_out = |(status_q & mask_q);

endmodule

// File: rtl/gpio_irq_port_chk.sv
// Property checker for gpio_irq_port, bound to every instance.
// Assumes: register offsets 0x08 (pad status) and 0x18 (status), window 0x00-0x1F.
module gpio_irq_port_chk #(
    parameter int unsigned LINES  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [LINES-1:0]  bus_wdata,
    input logic [LINES-1:0]  bus_rdata,
    input logic [LINES-1:0]  pad_out,
    input logic [LINES-1:0]  pad_oe,
    input logic              irq_out,
    input logic [LINES-1:0]  status_q,
    input logic [LINES-1:0]  dir_q,
    input logic [LINES-1:0]  mask_q
);

    localparam logic [ADDR_W-1:0] A_PAD  = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h18);

    // R1: first cycle out of reset starts clean.
    a_r1_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status_q == '0 && pad_out == '0 && pad_oe == '0 && !irq_out));

    // R4: pad status read never shows output lines.
    a_r4_pad_hides_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_write && bus_addr == A_PAD) |-> ((bus_rdata & dir_q) == '0));

    // R8: output lines never gain a status bit.
    a_r8_output_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q) & $past(dir_q)) == '0));

    // R9: written ones are clear in the following cycle.
    a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_write && bus_addr == A_STAT) |=> ((status_q & $past(bus_wdata)) == '0));

    // R10: an interrupt needs at least one enabled mask bit.
    a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (mask_q != '0));

    // R12: reads outside the window return zero.
    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_write && (bus_addr >> 5) != '0) |-> (bus_rdata == '0));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq_out   (irq_out),
    .status_q  (status_q),
    .dir_q     (dir_q),
    .mask_q    (mask_q)
);

// File: tb/gpio_irq_port_bench.sv
// Scoreboard bench: tasks queue expected values, a monitor compares them.
// Instance u_gpio_irq_port has the both-edges register; u_noboth lacks it.
module gpio_irq_port_bench;

    localparam int AW = 8;
    localparam logic [AW-1:0] O_DATA = 8'h00, O_DIR = 8'h04, O_PAD = 8'h08,
        O_CLO = 8'h0C, O_CHI = 8'h10, O_MASK = 8'h14, O_STAT = 8'h18, O_BOTH = 8'h1C;
    localparam int S_A = 0, S_B = 1, S_IRQ = 2, S_OUT = 3, S_OE = 4;

    typedef struct {
        int          src;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   pad_in = '0;
    logic [31:0]   rdata_a, rdata_b, out_a, out_b, oe_a, oe_b;
    logic          irq_a, irq_b;
    logic          probe_on = 1'b0;
    item_t         q[$];
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_port #(.ADDR_W(AW), .HAS_BOTH_EDGE(1'b1)) u_gpio_irq_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
        .pad_in(pad_in), .pad_out(out_a), .pad_oe(oe_a), .irq_out(irq_a));

    gpio_irq_port #(.ADDR_W(AW), .HAS_BOTH_EDGE(1'b0)) u_noboth (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
        .pad_in(pad_in), .pad_out(out_b), .pad_oe(oe_b), .irq_out(irq_b));

    // Monitor: compare the observed value against the oldest queued item.
    always begin
        @(negedge clk);
        #1;
        if (probe_on) begin
            if (q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: actual none expected item");
            end else begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.src)
                    S_A:     act = rdata_a;
                    S_B:     act = rdata_b;
                    S_IRQ:   act = {31'b0, irq_a};
                    S_OUT:   act = out_a;
                    default: act = oe_a;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0;
    endtask

    task automatic chk_rd(input int src, input logic [AW-1:0] a, input logic [31:0] e,
                          input string tag);
        item_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a; probe_on = 1'b1;
        it.src = src; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        bus_sel = 1'b0; probe_on = 1'b0;
    endtask

    task automatic chk_pin(input int src, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        probe_on = 1'b1;
        it.src = src; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        probe_on = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pad(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
        idle(3);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, checked while reset is held.
        chk_rd(S_A, O_DATA, 32'h0, "R1 data");
        chk_rd(S_A, O_DIR,  32'h0, "R1 dir");
        chk_rd(S_A, O_PAD,  32'h0, "R1 pad");
        chk_rd(S_A, O_CLO,  32'h0, "R1 cfglo");
        chk_rd(S_A, O_CHI,  32'h0, "R1 cfghi");
        chk_rd(S_A, O_MASK, 32'h0, "R1 mask");
        chk_rd(S_A, O_STAT, 32'h0, "R1 status");
        chk_rd(S_A, O_BOTH, 32'h0, "R1 both");
        chk_pin(S_IRQ, 32'h0, "R1 irq");
        chk_pin(S_OUT, 32'h0, "R1 pad_out");
        chk_pin(S_OE,  32'h0, "R1 pad_oe");
        @(negedge clk) rst_n = 1'b1;
        idle(3);

        // R5: mode 00 with pads low fires on every line; R10 mask 0 keeps irq low.
        chk_rd(S_A, O_STAT, 32'hFFFF_FFFF, "R5 level low");
        chk_pin(S_IRQ, 32'h0, "R10 masked");

        // R2/R3/R4: direction, data mix and pad status.
        wr(O_DATA, 32'hA5A5_0F0F);
        wr(O_DIR,  32'hFFFF_0000);
        chk_pin(S_OUT, 32'hA5A5_0F0F, "R2 pad_out");
        chk_pin(S_OE,  32'hFFFF_0000, "R2 pad_oe");
        set_pad(32'h1234_5678);
        chk_rd(S_A, O_DATA, 32'hA5A5_5678, "R3 data mix");
        chk_rd(S_A, O_PAD,  32'h0000_5678, "R4 pad status");

        // R6: lines 0-15 rising, 16-31 falling.
        wr(O_CLO, 32'hAAAA_AAAA);
        wr(O_CHI, 32'hFFFF_FFFF);
        wr(O_DIR, 32'h0);
        wr(O_DATA, 32'h0);
        set_pad(32'h0);
        wr(O_STAT, 32'hFFFF_FFFF);
        chk_rd(S_A, O_STAT, 32'h0, "R9 clear all");
        chk_rd(S_A, O_CLO, 32'hAAAA_AAAA, "R6 cfglo");
        chk_rd(S_A, O_CHI, 32'hFFFF_FFFF, "R6 cfghi");
        set_pad(32'h0001_0001);
        chk_rd(S_A, O_STAT, 32'h0000_0001, "R6 rising");
        set_pad(32'h0);
        chk_rd(S_A, O_STAT, 32'h0001_0001, "R6 falling");

        // R10: interrupt aggregation.
        wr(O_MASK, 32'h0001_0000);
        chk_pin(S_IRQ, 32'h1, "R10 irq on");
        wr(O_MASK, 32'h0000_0002);
        chk_pin(S_IRQ, 32'h0, "R10 irq off");
        chk_rd(S_A, O_MASK, 32'h0000_0002, "R12 mask offset");

        // R9: one bit cleared, zeros leave others.
        wr(O_STAT, 32'h0000_0001);
        chk_rd(S_A, O_STAT, 32'h0001_0000, "R9 partial clear");

        // R7/R11: falling edge on a rising-mode line with the override.
        wr(O_STAT, 32'hFFFF_FFFF);
        wr(O_BOTH, 32'h0000_0004);
        chk_rd(S_A, O_BOTH, 32'h0000_0004, "R7 both readback");
        chk_rd(S_B, O_BOTH, 32'h0, "R11 absent reads 0");
        set_pad(32'h0000_0004);
        wr(O_STAT, 32'hFFFF_FFFF);
        set_pad(32'h0);
        chk_rd(S_A, O_STAT, 32'h0000_0004, "R7 falling via override");
        chk_rd(S_B, O_STAT, 32'h0, "R11 no override");

        // R5/R9: line 3 active-high level, re-set after clear.
        wr(O_CLO, 32'hAAAA_AA6A);
        wr(O_STAT, 32'hFFFF_FFFF);
        set_pad(32'h0000_0008);
        chk_rd(S_A, O_STAT, 32'h0000_0008, "R5 level high");
        wr(O_STAT, 32'h0000_0008);
        chk_rd(S_A, O_STAT, 32'h0000_0008, "R9 level re-set");
        set_pad(32'h0);
        wr(O_STAT, 32'hFFFF_FFFF);
        chk_rd(S_A, O_STAT, 32'h0, "R5 level inactive");

        // R8: an output line sees an edge but records nothing.
        wr(O_DIR, 32'h0000_0010);
        set_pad(32'h0000_0010);
        chk_rd(S_A, O_STAT, 32'h0, "R8 output no event");
        chk_rd(S_A, O_PAD,  32'h0, "R4 output hidden");
        chk_rd(S_A, O_DATA, 32'h0, "R3 output from data reg");
        chk_pin(S_OE, 32'h0000_0010, "R2 pad_oe line4");

        // R12: unmapped and misaligned accesses.
        wr(8'h21, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        chk_rd(S_A, O_DATA, 32'h0, "R12 misaligned write ignored");
        chk_pin(S_OUT, 32'h0, "R12 pad_out unchanged");
        chk_rd(S_A, 8'h20, 32'h0, "R12 unmapped read");
        chk_rd(S_A, 8'h05, 32'h0, "R12 misaligned read");

        idle(2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule